// File: doc/BRIEF.md
# Calendar Clock with Daylight-Saving Adjustment

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, weekday, day of month, month and a two-digit year, and moves them forward by one second for every accepted tick. It handles month lengths, leap years, the year wrap and the weekday wrap. Every field is presented in the format that the control inputs select. One input picks packed BCD or plain binary. Another picks 24-hour counting or 12-hour counting with a PM flag.

Software presets the time through a load port. This is done while the update-inhibit input holds the counters still. Loaded bytes are read in the same format as the outputs. When daylight saving is enabled, the block checks at each midnight whether the new day is a spring-forward Sunday or a fall-back Sunday. On that day it skips or repeats the hour that follows 1:59:59 AM. The fall-back repeat happens only once per day. A one-clock pulse marks each completed advance.

Top module: `cal_clock_dst`

## Requirements
- R1: After reset the clock reads 00:00:00, weekday 1, day 1, month 1, year 0, and `upd_done` is low.
- R2: In a clock cycle where `tick` is 1 and `inhibit` is 0, the time advances by one second, carrying through minutes, hours and the calendar. `upd_done` is high for exactly the next clock cycle.
- R3: `fmt_bin`=1 presents and accepts all seven fields as binary numbers. `fmt_bin`=0 uses packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R4: `hr24`=1 counts hours 0 to 23. `hr24`=0 shows hours 1 to 12, with bit 7 set for PM. In that mode 11:59:59 AM is followed by 12:00:00 PM (BCD 0x92), and 11:59:59 PM is followed by 12:00:00 AM (BCD 0x12) on the next day.
- R5: Months have 30 or 31 days as usual. February has 29 days when the year is divisible by 4 and 28 otherwise. December rolls over to January, and year 99 rolls over to 00.
- R6: The weekday counts from 1 to 7, where 1 is Sunday, and 7 wraps to 1 at midnight.
- R7: While `inhibit` is 1, `tick` changes nothing and produces no `upd_done`. A cycle with `load_en`=1 copies all seven load bytes into the clock.
- R8: When `inhibit` is 0, `load_en` has no effect.
- R9: Suppose `dst_en` was 1 at the midnight that began an April day with weekday 1 and day 7 or less, and `dst_en` is still 1. Then the tick after 01:59:59 gives 03:00:00.
- R10: Suppose `dst_en` was 1 at the midnight that began an October day with weekday 1 and day 25 or more. Then the first tick after 01:59:59 gives 01:00:00. The second pass through 01:59:59 goes on to 02:00:00.
- R11: No adjustment happens when `dst_en` is 0 at the 01:59:59 tick. No adjustment happens on a day whose midnight test ran with `dst_en` at 0. A load also cancels any pending adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-second advance request |
| inhibit | input | 1 | Freezes counting and enables loading |
| load_en | input | 1 | Load strobe, honoured only while inhibited |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load (bit 7 = PM in 12-hour mode) |
| ld_wday | input | 8 | Weekday to load (1 = Sunday) |
| ld_day | input | 8 | Day of month to load |
| ld_mon | input | 8 | Month to load |
| ld_year | input | 8 | Two-digit year to load |
| fmt_bin | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Daylight-saving adjustment enable |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| wday_o | output | 8 | Current weekday |
| day_o | output | 8 | Current day of month |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |
| upd_done | output | 1 | One-clock pulse after each advance |

## Verification
The bench targets several boundaries. At the 12-hour noon and midnight crossings, a design that handles the PM flag wrongly shows 0x12 and 0x92 swapped, or never moves the date on. February is tested in a leap year and a common year, and December 31 of year 99 is tested too; a wrong month-length rule or a missing wrap shows a day 29 that should not exist, or a year of 100. The fall-back Sunday is followed through both passes of 01:59:59, which exposes a design that never marks the fall-back as done, because it would loop at 01:00 for ever. Two cases change `dst_en` between the midnight test and the jump, and they catch logic that samples the enable only at one of those two moments.

// File: rtl/cal_clk_pkg.sv
package cal_clk_pkg;
   localparam int NF     = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HR   = 2;
   localparam int F_WDAY = 3;
   localparam int F_DAY  = 4;
   localparam int F_MON  = 5;
   localparam int F_YR   = 6;

   // all counters are held in plain binary
   typedef struct packed {
      logic [6:0] yr;
      logic [3:0] mon;
      logic [4:0] day;
      logic [2:0] wday;
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } cal_state_t;

   function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
      return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr,
                                            input int leap_period);
      case (mon)
         4'd2:                     return ((int'(yr) % leap_period) == 0) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
         default:                  return 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/cal_load_dec.sv
module cal_load_dec import cal_clk_pkg::*; (
   input  logic [NF-1:0][7:0] raw,
   input  logic               fmt_bin,
   input  logic               hr24,
   output cal_state_t         st
);
   logic [NF-1:0][6:0] val;

   for (genvar i = 0; i < NF; i++) begin : g_fld
      logic [7:0] src;
      if (i == F_HR) begin : g_hr
         // PM flag is stripped before conversion in 12-hour mode
         assign src = hr24 ? raw[i] : {1'b0, raw[i][6:0]};
      end else begin : g_plain
         assign src = raw[i];
      end
      assign val[i] = fmt_bin ? src[6:0] : bcd_to_bin(src);
   end

   logic       pm;
   logic [6:0] hv;

   always_comb begin
      pm      = raw[F_HR][7] & ~hr24;
      hv      = val[F_HR];
      st.sc   = 6'(val[F_SEC]);
      st.mn   = 6'(val[F_MIN]);
      st.wday = 3'(val[F_WDAY]);
      st.day  = 5'(val[F_DAY]);
      st.mon  = 4'(val[F_MON]);
      st.yr   = val[F_YR];
      if (hr24)     st.hr = 5'(hv);
      else if (pm)  st.hr = (hv == 7'd12) ? 5'd12 : 5'(hv + 7'd12);
      else          st.hr = (hv == 7'd12) ? 5'd0  : 5'(hv);
   end
endmodule

// File: rtl/cal_view_enc.sv
module cal_view_enc import cal_clk_pkg::*; (
   input  cal_state_t         st,
   input  logic               fmt_bin,
   input  logic               hr24,
   output logic [NF-1:0][7:0] view
);
   logic [NF-1:0][6:0] raw;
   logic [4:0]         h12;
   logic               pm;

   always_comb begin
      pm = (st.hr >= 5'd12);
      if (st.hr == 5'd0)       h12 = 5'd12;
      else if (st.hr > 5'd12)  h12 = st.hr - 5'd12;
      else                     h12 = st.hr;
      raw         = '0;
      raw[F_SEC]  = 7'(st.sc);
      raw[F_MIN]  = 7'(st.mn);
      raw[F_HR]   = hr24 ? 7'(st.hr) : 7'(h12);
      raw[F_WDAY] = 7'(st.wday);
      raw[F_DAY]  = 7'(st.day);
      raw[F_MON]  = 7'(st.mon);
      raw[F_YR]   = st.yr;
   end

   for (genvar i = 0; i < NF; i++) begin : g_fld
      logic [7:0] coded;
      assign coded = fmt_bin ? {1'b0, raw[i]} : bin_to_bcd(raw[i]);
      if (i == F_HR) begin : g_hr
         assign view[i] = {coded[7] | (pm & ~hr24), coded[6:0]};
      end else begin : g_plain
         assign view[i] = coded;
      end
   end
endmodule

// File: rtl/cal_dst_ctl.sv
module cal_dst_ctl #(
   parameter int SPRING_MON   = 4,
   parameter int FALL_MON     = 10,
   parameter int FIRST_WK_MAX = 7,
   parameter int LAST_WK_MIN  = 25,
   parameter int SUNDAY       = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dst_en,
   input  logic       clear,
   input  logic       midnight,
   input  logic [3:0] nx_mon,
   input  logic [4:0] nx_day,
   input  logic [2:0] nx_wday,
   input  logic       at_edge,
   output logic       spring_go,
   output logic       fall_go
);
   logic spring_arm, fall_arm, fall_used;
   logic is_sun;

   assign is_sun = (nx_wday == 3'(SUNDAY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spring_arm <= 1'b0;
         fall_arm   <= 1'b0;
         fall_used  <= 1'b0;
      end else if (clear) begin
         spring_arm <= 1'b0;
         fall_arm   <= 1'b0;
         fall_used  <= 1'b0;
      end else if (midnight) begin
         spring_arm <= dst_en && is_sun && nx_mon == 4'(SPRING_MON) && nx_day <= 5'(FIRST_WK_MAX);
         fall_arm   <= dst_en && is_sun && nx_mon == 4'(FALL_MON)   && nx_day >= 5'(LAST_WK_MIN);
         fall_used  <= 1'b0;
      end else if (fall_go) begin
         fall_used  <= 1'b1;
      end
   end

   assign spring_go = at_edge && dst_en && spring_arm;
   assign fall_go   = at_edge && dst_en && fall_arm && !fall_used;

   // R11
   arm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (midnight && !clear && !dst_en) |=> (!spring_arm && !fall_arm));

   // R10
   fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_go && !clear && !midnight) |=> !fall_go);
endmodule

// File: rtl/cal_clock_dst.sv
module cal_clock_dst import cal_clk_pkg::*; #(
   parameter int YEAR_SPAN   = 100,
   parameter int LEAP_PERIOD = 4,
   parameter int JUMP_HOUR   = 1,
   parameter bit HAS_DST     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       inhibit,
   input  logic       load_en,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_hour,
   input  logic [7:0] ld_wday,
   input  logic [7:0] ld_day,
   input  logic [7:0] ld_mon,
   input  logic [7:0] ld_year,
   input  logic       fmt_bin,
   input  logic       hr24,
   input  logic       dst_en,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] day_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o,
   output logic       upd_done
);
   localparam logic [6:0] YR_LAST  = 7'(YEAR_SPAN - 1);
   localparam logic [4:0] HR_JUMP  = 5'(JUMP_HOUR);
   localparam logic [4:0] HR_SKIP  = 5'(JUMP_HOUR + 2);
   localparam cal_state_t RST_ST   = '{yr: 7'd0, mon: 4'd1, day: 5'd1, wday: 3'd1,
                                       hr: 5'd0, mn: 6'd0, sc: 6'd0};

   if (YEAR_SPAN < 2 || YEAR_SPAN > 100) begin : g_bad_span
      $error("YEAR_SPAN must lie in 2..100");
   end
   if (LEAP_PERIOD < 1) begin : g_bad_leap
      $error("LEAP_PERIOD must be positive");
   end
   if (JUMP_HOUR < 0 || JUMP_HOUR > 21) begin : g_bad_jump
      $error("JUMP_HOUR must lie in 0..21");
   end

   cal_state_t         st_q, nx, ld_st;
   logic [NF-1:0][7:0] ld_raw, view;
   logic               step, do_load, roll_day, at_edge, spring_go, fall_go;
   logic [4:0]         dim;

   assign step    = tick && !inhibit;
   assign do_load = inhibit && load_en;
   assign dim     = month_len(st_q.mon, st_q.yr, LEAP_PERIOD);
   assign at_edge = step && st_q.hr == HR_JUMP && st_q.mn == 6'd59 && st_q.sc == 6'd59;

   always_comb begin
      ld_raw         = '0;
      ld_raw[F_SEC]  = ld_sec;
      ld_raw[F_MIN]  = ld_min;
      ld_raw[F_HR]   = ld_hour;
      ld_raw[F_WDAY] = ld_wday;
      ld_raw[F_DAY]  = ld_day;
      ld_raw[F_MON]  = ld_mon;
      ld_raw[F_YR]   = ld_year;
   end

   cal_load_dec u_dec (.raw(ld_raw), .fmt_bin(fmt_bin), .hr24(hr24), .st(ld_st));
   cal_view_enc u_enc (.st(st_q),    .fmt_bin(fmt_bin), .hr24(hr24), .view(view));

   always_comb begin
      nx       = st_q;
      roll_day = 1'b0;
      if (st_q.sc == 6'd59) begin
         nx.sc = 6'd0;
         if (st_q.mn == 6'd59) begin
            nx.mn = 6'd0;
            if (st_q.hr == 5'd23) begin
               nx.hr    = 5'd0;
               roll_day = 1'b1;
            end else begin
               nx.hr = st_q.hr + 5'd1;
            end
         end else begin
            nx.mn = st_q.mn + 6'd1;
         end
      end else begin
         nx.sc = st_q.sc + 6'd1;
      end
      if (roll_day) begin
         nx.wday = (st_q.wday >= 3'd7) ? 3'd1 : st_q.wday + 3'd1;
         if (st_q.day >= dim) begin
            nx.day = 5'd1;
            if (st_q.mon >= 4'd12) begin
               nx.mon = 4'd1;
               nx.yr  = (st_q.yr >= YR_LAST) ? 7'd0 : st_q.yr + 7'd1;
            end else begin
               nx.mon = st_q.mon + 4'd1;
            end
         end else begin
            nx.day = st_q.day + 5'd1;
         end
      end
      if (spring_go) begin
         nx.hr = HR_SKIP;
         nx.mn = 6'd0;
         nx.sc = 6'd0;
      end
      if (fall_go) begin
         nx.hr = HR_JUMP;
         nx.mn = 6'd0;
         nx.sc = 6'd0;
      end
   end

   if (HAS_DST) begin : g_dst
      cal_dst_ctl u_dst (
         .clk      (clk),
         .rst_n    (rst_n),
         .dst_en   (dst_en),
         .clear    (do_load),
         .midnight (step && roll_day),
         .nx_mon   (nx.mon),
         .nx_day   (nx.day),
         .nx_wday  (nx.wday),
         .at_edge  (at_edge),
         .spring_go(spring_go),
         .fall_go  (fall_go)
      );
   end else begin : g_no_dst
      assign spring_go = 1'b0;
      assign fall_go   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RST_ST;
         upd_done <= 1'b0;
      end else begin
         upd_done <= step;
         if (step)          st_q <= nx;
         else if (do_load)  st_q <= ld_st;
      end
   end

   assign sec_o  = view[F_SEC];
   assign min_o  = view[F_MIN];
   assign hour_o = view[F_HR];
   assign wday_o = view[F_WDAY];
   assign day_o  = view[F_DAY];
   assign mon_o  = view[F_MON];
   assign year_o = view[F_YR];

   // R2
   upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> $past(tick && !inhibit));

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && st_q.sc == 6'd59) |=> (st_q.sc == 6'd0));

   // R7
   inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit && !load_en) |=> $stable(st_q));

   // R8
   load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit && !tick) |=> $stable(st_q));

   // R9
   spring_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spring_go |=> (st_q.hr == HR_SKIP && st_q.mn == 6'd0 && st_q.sc == 6'd0));

   // R10
   fall_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_go |=> (st_q.hr == HR_JUMP && st_q.mn == 6'd0 && st_q.sc == 6'd0));
endmodule

// File: tb/cal_clock_dst_bench.sv
module cal_clock_dst_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, inhibit = 1'b0, load_en = 1'b0;
   logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_wday = '0;
   logic [7:0] ld_day = '0, ld_mon = '0, ld_year = '0;
   logic       fmt_bin = 1'b0, hr24 = 1'b1, dst_en = 1'b0;
   logic [7:0] sec_o, min_o, hour_o, wday_o, day_o, mon_o, year_o;
   logic       upd_done;
   int         n_chk = 0;
   int         n_fail = 0;

   always #2.5 clk = ~clk;

   cal_clock_dst u_cal_clock_dst (
      .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit(inhibit), .load_en(load_en),
      .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_wday(ld_wday),
      .ld_day(ld_day), .ld_mon(ld_mon), .ld_year(ld_year),
      .fmt_bin(fmt_bin), .hr24(hr24), .dst_en(dst_en),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
      .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .upd_done(upd_done)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_time(input string req, input logic [7:0] h,
                           input logic [7:0] m, input logic [7:0] s);
      chk(req, "hour", hour_o, h);
      chk(req, "min",  min_o,  m);
      chk(req, "sec",  sec_o,  s);
   endtask

   task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                       input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                       input logic [7:0] y);
      @(negedge clk);
      inhibit = 1'b1; load_en = 1'b1;
      ld_hour = h; ld_min = m; ld_sec = s; ld_wday = wd;
      ld_day = d; ld_mon = mo; ld_year = y;
      @(negedge clk);
      load_en = 1'b0; inhibit = 1'b0;
   endtask

   task automatic tick_once();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) tick_once();
   endtask

   task automatic t_reset();
      chk("R1", "sec",  sec_o,  8'h00);
      chk("R1", "hour", hour_o, 8'h00);
      chk("R1", "wday", wday_o, 8'h01);
      chk("R1", "day",  day_o,  8'h01);
      chk("R1", "mon",  mon_o,  8'h01);
      chk("R1", "year", year_o, 8'h00);
      chk("R1", "upd",  {7'd0, upd_done}, 8'h00);
   endtask

   task automatic t_carry();
      load(8'h10, 8'h14, 8'h59, 8'h02, 8'h10, 8'h03, 8'h21);
      tick_once();
      chk_time("R2", 8'h10, 8'h15, 8'h00);
      load(8'h23, 8'h59, 8'h58, 8'h03, 8'h30, 8'h06, 8'h21);
      tick_once();
      chk("R2", "sec", sec_o, 8'h59);
      chk("R2", "upd high", {7'd0, upd_done}, 8'h01);
      @(negedge clk);
      chk("R2", "upd low", {7'd0, upd_done}, 8'h00);
      tick_once();
      chk_time("R2", 8'h00, 8'h00, 8'h00);
      chk("R2", "day",  day_o,  8'h01);
      chk("R2", "mon",  mon_o,  8'h07);
      chk("R6", "wday", wday_o, 8'h04);
   endtask

   task automatic t_format();
      fmt_bin = 1'b1;
      load(8'd17, 8'd30, 8'd45, 8'd2, 8'd28, 8'd11, 8'd42);
      chk("R3", "bin sec",  sec_o,  8'd45);
      chk("R3", "bin hour", hour_o, 8'd17);
      chk("R3", "bin year", year_o, 8'd42);
      @(negedge clk); hr24 = 1'b0; #1;
      chk("R4", "bin 12h pm", hour_o, 8'h85);
      @(negedge clk); hr24 = 1'b1; fmt_bin = 1'b0; #1;
      chk("R3", "bcd sec",  sec_o,  8'h45);
      chk("R3", "bcd hour", hour_o, 8'h17);
      chk("R3", "bcd mon",  mon_o,  8'h11);
      chk("R3", "bcd day",  day_o,  8'h28);
   endtask

   task automatic t_12h();
      hr24 = 1'b0;
      load(8'h11, 8'h59, 8'h59, 8'h02, 8'h14, 8'h05, 8'h24);
      tick_once();
      chk_time("R4", 8'h92, 8'h00, 8'h00);
      chk("R4", "date same", day_o, 8'h14);
      load(8'h91, 8'h59, 8'h59, 8'h03, 8'h15, 8'h05, 8'h24);
      tick_once();
      chk_time("R4", 8'h12, 8'h00, 8'h00);
      chk("R4", "date next", day_o, 8'h16);
      @(negedge clk); hr24 = 1'b1; #1;
      chk("R4", "24h midnight", hour_o, 8'h00);
   endtask

   task automatic t_calendar();
      load(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h24);
      tick_once();
      chk("R5", "leap day", day_o, 8'h29);
      chk("R5", "leap mon", mon_o, 8'h02);
      chk("R6", "wday wrap", wday_o, 8'h01);
      load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h23);
      tick_once();
      chk("R5", "common day", day_o, 8'h01);
      chk("R5", "common mon", mon_o, 8'h03);
      load(8'h23, 8'h59, 8'h59, 8'h05, 8'h30, 8'h04, 8'h23);
      tick_once();
      chk("R5", "apr end mon", mon_o, 8'h05);
      load(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
      tick_once();
      chk("R5", "year wrap", year_o, 8'h00);
      chk("R5", "jan",       mon_o,  8'h01);
      chk("R5", "day 1",     day_o,  8'h01);
   endtask

   task automatic t_inhibit();
      load(8'h08, 8'h20, 8'h30, 8'h02, 8'h09, 8'h09, 8'h20);
      inhibit = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick_once();
         chk("R7", "frozen sec", sec_o, 8'h30);
         chk("R7", "no upd", {7'd0, upd_done}, 8'h00);
      end
      inhibit = 1'b0;
      chk("R7", "loaded hour", hour_o, 8'h08);
   endtask

   task automatic t_load_ignored();
      @(negedge clk);
      load_en = 1'b1;
      ld_hour = 8'h05; ld_min = 8'h05; ld_sec = 8'h07;
      ld_day = 8'h02; ld_mon = 8'h02; ld_year = 8'h02; ld_wday = 8'h06;
      @(negedge clk);
      load_en = 1'b0;
      chk_time("R8", 8'h08, 8'h20, 8'h30);
      chk("R8", "day", day_o, 8'h09);
      chk("R8", "wday", wday_o, 8'h02);
   endtask

   task automatic t_spring();
      dst_en = 1'b1;
      load(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h03, 8'h24);
      tick_once();
      chk("R9", "apr 1 mon",  mon_o,  8'h04);
      chk("R9", "apr 1 wday", wday_o, 8'h01);
      run(7199);
      chk_time("R9", 8'h01, 8'h59, 8'h59);
      tick_once();
      chk_time("R9", 8'h03, 8'h00, 8'h00);
   endtask

   task automatic t_fall();
      dst_en = 1'b1;
      load(8'h23, 8'h59, 8'h59, 8'h07, 8'h24, 8'h10, 8'h24);
      tick_once();
      chk("R10", "oct 25", day_o, 8'h25);
      run(7199);
      chk_time("R10", 8'h01, 8'h59, 8'h59);
      tick_once();
      chk_time("R10", 8'h01, 8'h00, 8'h00);
      run(3599);
      chk_time("R10", 8'h01, 8'h59, 8'h59);
      tick_once();
      chk_time("R10", 8'h02, 8'h00, 8'h00);
   endtask

   task automatic t_dst_late_enable();
      dst_en = 1'b0;
      load(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h03, 8'h25);
      tick_once();
      dst_en = 1'b1;
      run(7200);
      chk_time("R11", 8'h02, 8'h00, 8'h00);
   endtask

   task automatic t_dst_off_at_jump();
      dst_en = 1'b1;
      load(8'h23, 8'h59, 8'h59, 8'h07, 8'h24, 8'h10, 8'h25);
      tick_once();
      dst_en = 1'b0;
      run(7200);
      chk_time("R11", 8'h02, 8'h00, 8'h00);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_carry();
      t_format();
      t_12h();
      t_calendar();
      t_inhibit();
      t_load_ignored();
      t_spring();
      t_fall();
      t_dst_late_enable();
      t_dst_off_at_jump();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule